// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat memory burst. A full starting address is captured when either of two active-low load strobes is sampled low. One is a primary strobe. The other is a secondary strobe, which can also mark the burst as a write. On later clock edges, a burst-advance input moves the two low address bits to the next position. The upper bits keep the value they were loaded with until the next load.

A static order-select input picks the sequence of the low bits. When it is high, the sequence is interleaved: the start bits XORed with the beat number. When it is low, the sequence is linear: the start bits plus the beat number, modulo 4. In both orders the sequence wraps after four beats and keeps cycling while advances continue.

A small controller holds the burst kind in one of three states. ST_IDLE is the state after reset, before any load. ST_RBURST is a read burst. ST_WBURST is a write burst. From any state, T_PLOAD (primary strobe low) enters ST_RBURST. T_SLOAD_RD (secondary strobe low, primary high, write qualifier high) enters ST_RBURST. T_SLOAD_WR (secondary strobe low, primary high, write qualifier low) enters ST_WBURST. With no strobe low, T_STAY keeps the current state. The address output is taken combinationally from the loaded base address and a 2-bit beat counter, and the counter clears on every load.

Top module: `burst_addr_gen`

## Requirements
- R1: When either strobe (`pstb_n` or `cstb_n`) is sampled low, the next output equals `ld_addr` and the beat position returns to 0.
- R2: When `pstb_n` is sampled low, the burst is a read burst whatever `cstb_n` and `wr_n` are. The `adv_n` value on that edge is ignored, so the output equals `ld_addr` unchanged.
- R3: Bits `addr[AW-1:2]` stay at their loaded value on every edge where neither strobe is low.
- R4: With `interleave` = 1, beat k (0..3) outputs low bits equal to start XOR k. For example, start 10 gives 10, 11, 00, 01.
- R5: With `interleave` = 0, beat k outputs low bits equal to (start + k) mod 4. For example, start 11 gives 11, 00, 01, 10.
- R6: The beat position advances by one only on an edge where both strobes are high and `adv_n` is low. With a strobe low, a load happens instead.
- R7: An edge with both strobes high and `adv_n` high leaves the output unchanged, which suspends the burst.
- R8: In a write burst (loaded by `cstb_n` low with `pstb_n` high and `wr_n` low), an edge advances only when `adv_n` and `wr_n` are both low. A read burst ignores `wr_n`.
- R9: After the fourth beat, a further advance returns to beat 0, and the sequence repeats without stopping.
- R10: A synchronous `rst` high clears the output to 0. Advances that arrive before the first load after reset leave the output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_addr | input | AW | Address captured on a load edge |
| pstb_n | input | 1 | Primary load strobe, active low, always starts a read burst |
| cstb_n | input | 1 | Secondary load strobe, active low, burst kind taken from `wr_n` |
| adv_n | input | 1 | Burst advance, active low |
| wr_n | input | 1 | Write qualifier, active low: sets the kind on a secondary load and gates advances in a write burst |
| interleave | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr | output | AW | Current beat address |

## Verification
The bench builds the block with AW = 6. This keeps the four upper bits small enough to be driven all-ones, all-zeros and mixed, so a carry leaking from the low bits into the upper field would show up. Both order settings are run from every start value. Write bursts are run with the qualifier toggled between beats, and both strobes are pressed on the same edge to exercise strobe precedence. A long pseudo-random phase with infrequent strobes drives many wraps past the fourth beat, compared on every clock against a behavioural model.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RBURST = 2'd1,
        ST_WBURST = 2'd2
    } burst_state_e;

endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pstb_n,
    input  logic cstb_n,
    input  logic adv_n,
    input  logic wr_n,
    output logic load,
    output logic step
);

    burst_state_e state_q, state_d;
    logic         strobes_idle;

    assign strobes_idle = pstb_n & cstb_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions: T_PLOAD, T_SLOAD_RD, T_SLOAD_WR, T_STAY
    always_comb begin
        state_d = state_q;
        if (!pstb_n)      state_d = ST_RBURST;
        else if (!cstb_n) state_d = wr_n ? ST_RBURST : ST_WBURST;
    end

    // outputs
    always_comb begin
        load = ~pstb_n | ~cstb_n;
        step = 1'b0;
        unique case (state_q)
            ST_IDLE:   step = 1'b0;
            ST_RBURST: step = strobes_idle & ~adv_n;
            ST_WBURST: step = strobes_idle & ~adv_n & ~wr_n;
            default:   step = 1'b0;
        endcase
    end

    assert_pload_read_R2: assert property (@(posedge clk) disable iff (rst)
        !pstb_n |=> state_q == ST_RBURST);

    assert_wbeat_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WBURST && wr_n) |-> !step);

    assert_idle_nostep_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && pstb_n && cstb_n) |=> state_q == ST_IDLE);

endmodule

// File: rtl/beat_counter.sv
module beat_counter
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [BEAT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1 && inc && !clr) |=> cnt == '0);

    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);

endmodule

// File: rtl/low_bit_map.sv
module low_bit_map
    import burst_pkg::*;
(
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] xor_seq;
    logic [BEAT_W-1:0] lin_seq;

    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
            assign xor_seq[gi] = start[gi] ^ beat[gi];
        end
    endgenerate

    assign lin_seq = start + beat;
    assign low     = interleave ? xor_seq : lin_seq;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ld_addr,
    input  logic          pstb_n,
    input  logic          cstb_n,
    input  logic          adv_n,
    input  logic          wr_n,
    input  logic          interleave,
    output logic [AW-1:0] addr
);

    localparam int UW = AW - BEAT_W;

    logic              load;
    logic              step;
    logic [AW-1:0]     base_q;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;

    burst_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .pstb_n (pstb_n),
        .cstb_n (cstb_n),
        .adv_n  (adv_n),
        .wr_n   (wr_n),
        .load   (load),
        .step   (step)
    );

    beat_counter u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (load),
        .inc (step),
        .cnt (beat)
    );

    always_ff @(posedge clk) begin
        if (rst)       base_q <= '0;
        else if (load) base_q <= ld_addr;
    end

    low_bit_map u_map (
        .start      (base_q[BEAT_W-1:0]),
        .beat       (beat),
        .interleave (interleave),
        .low        (low)
    );

    assign addr = {base_q[AW-1:BEAT_W], low};

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        (!pstb_n || !cstb_n) |=> addr == $past(ld_addr));

    assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        (pstb_n && cstb_n) |=> addr[AW-1:BEAT_W] == $past(addr[AW-1:BEAT_W]));

    assert_suspend_R7: assert property (@(posedge clk) disable iff (rst)
        (pstb_n && cstb_n && adv_n) |=>
            (addr == $past(addr) || interleave != $past(interleave)));

    initial begin
        assert_width_ok: assert (UW >= 1);
    end

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] ld_addr;
    logic          pstb_n, cstb_n, adv_n, wr_n, interleave;
    logic [AW-1:0] addr;

    int vectors = 0;
    int errors  = 0;

    // behavioural model state
    int m_upper, m_start, m_beat, m_kind; // kind: 0 idle, 1 read, 2 write

    always #5 clk = ~clk;

    burst_addr_gen #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .ld_addr(ld_addr), .pstb_n(pstb_n),
        .cstb_n(cstb_n), .adv_n(adv_n), .wr_n(wr_n),
        .interleave(interleave), .addr(addr)
    );

    function automatic logic [AW-1:0] model_addr();
        int lo;
        if (interleave) lo = m_start ^ m_beat;
        else            lo = (m_start + m_beat) % 4;
        return AW'((m_upper << 2) | lo);
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_upper = 0; m_start = 0; m_beat = 0; m_kind = 0;
        end else if (!pstb_n || !cstb_n) begin
            m_upper = int'(ld_addr) >> 2;
            m_start = int'(ld_addr) & 3;
            m_beat  = 0;
            m_kind  = (!pstb_n) ? 1 : (wr_n ? 1 : 2);
        end else if (m_kind != 0 && !adv_n && (m_kind == 1 || !wr_n)) begin
            m_beat = (m_beat + 1) % 4;
        end
    endtask

    // one clock: inputs are already set at a falling edge
    task automatic cyc(input string tag);
        logic [AW-1:0] exp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp = model_addr();
        vectors++;
        if (addr !== exp) begin
            errors++;
            $display("FAIL %s: addr=%b expected=%b at %0t", tag, addr, exp, $time);
        end
    endtask

    task automatic drive(input logic p, input logic c, input logic a,
                         input logic w, input logic [AW-1:0] la);
        pstb_n = p; cstb_n = c; adv_n = a; wr_n = w; ld_addr = la;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; interleave = 1'b1;
        drive(1, 1, 1, 1, '0);
        @(negedge clk);
        cyc("R10"); cyc("R10");
        rst = 1'b0;
        // advances before any load stay at zero
        drive(1, 1, 0, 0, 6'h2a);
        cyc("R10"); cyc("R10");

        // interleaved burst from start 10, adv low on the load edge ignored
        drive(0, 1, 0, 0, 6'b101110);
        cyc("R2");
        drive(1, 1, 0, 1, 6'h00);
        cyc("R4"); cyc("R4"); cyc("R4");
        cyc("R9"); cyc("R9");
        // suspend
        drive(1, 1, 1, 0, 6'h3f);
        cyc("R7"); cyc("R7");
        cyc("R3");

        // secondary strobe reload while adv low: load, not advance
        drive(1, 0, 0, 1, 6'b111101);
        cyc("R6");
        drive(1, 1, 0, 1, 6'h00);
        cyc("R6"); cyc("R3");

        // linear order from start 11, mode changed with the load
        interleave = 1'b0;
        drive(0, 1, 1, 1, 6'b000011);
        cyc("R5");
        drive(1, 1, 0, 1, 6'h15);
        cyc("R5"); cyc("R5"); cyc("R5"); cyc("R9");

        // write burst through secondary strobe: wr gates advance
        interleave = 1'b1;
        drive(1, 0, 1, 0, 6'b010001);
        cyc("R1");
        drive(1, 1, 0, 1, 6'h00);
        cyc("R8"); cyc("R8");
        drive(1, 1, 0, 0, 6'h00);
        cyc("R8"); cyc("R8");
        drive(1, 1, 1, 0, 6'h00);
        cyc("R7");

        // both strobes with wr low: primary wins, read burst ignores wr
        drive(0, 0, 1, 0, 6'b110110);
        cyc("R2");
        drive(1, 1, 0, 1, 6'h00);
        cyc("R2"); cyc("R2");

        // every start value in both orders
        for (int mo = 0; mo < 2; mo++) begin
            for (int s = 0; s < 4; s++) begin
                interleave = mo[0];
                drive(1, 0, 0, 1, AW'((9 << 2) | s));
                cyc("R1");
                drive(1, 1, 0, 1, 6'h00);
                for (int b = 0; b < 5; b++) cyc(mo == 1 ? "R4" : "R5");
            end
        end

        // reset mid-burst
        rst = 1'b1;
        cyc("R10");
        rst = 1'b0;
        drive(1, 1, 0, 1, 6'h00);
        cyc("R10");

        // pseudo-random phase
        for (int i = 0; i < 3000; i++) begin
            logic ld;
            ld = ($urandom % 8) == 0;
            if (ld && ($urandom % 3) == 0) interleave = ~interleave;
            drive(ld ? logic'($urandom % 2) : 1'b1,
                  ld ? 1'b0 : 1'b1,
                  logic'($urandom % 2), logic'($urandom % 2),
                  AW'($urandom));
            if (ld && pstb_n) cstb_n = 1'b0;
            else if (ld) cstb_n = logic'($urandom % 2);
            cyc("R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule